// File: doc/BRIEF.md
# Fractional feedback divider calculator

This block converts a requested effective feedback-divider setting for a noise-tolerant PLL into two fields. The first is an integer divider. The second is an 8-bit offset-binary fraction word for the sigma-delta modulator. The conversion corrects for the frequency shift that the on-chip voltage detector will add.

The detector's code for the present supply is estimated as the rounded quotient of the supply (in microvolts) minus the detector offset, divided by the detector slope. The calibration value that is already applied is subtracted from that code. The result is clipped at the detection maximum and scaled by the detection coefficient. This correction is removed from the requested divider, which is held in fixed point with six fractional bits.

The integer part is clamped to the legal range, and each clamp raises a flag. The fractional part is re-encoded so that the one-half step the modulator adds internally is cancelled. A start pulse launches one calculation. The division runs one bit per cycle. A one-cycle done pulse presents the result, which then holds until the next calculation completes.

Top module: `fdiv_calc`

## Requirements
- R1: `ready_o` is high while idle. A `start_i` pulse is accepted only in a cycle where `ready_o` is high, and `ready_o` is low from the next cycle until the result is delivered. A `start_i` pulse, or any input change, while busy has no effect on the result in progress.
- R2: `done_o` is high for exactly one cycle, UV_W+1 clock cycles (22 by default) after the accepting edge. `ready_o` is high again in that same cycle.
- R3: The detector code is (uv_i - det_offs_i) / det_slope_i, rounded to the nearest integer with ties away from zero. This is done by dividing the magnitude and then applying the sign. det_slope_i must be nonzero.
- R4: The correction is (code - ext_cal_i), limited from above to det_max_i, then multiplied by coeff_i. ext_cal_i and det_max_i are two's complement and coeff_i is unsigned.
- R5: The scaled divider is n = n_eff_i*64 - correction. n_int_o = n >> 6 and the fraction is n[5:0].
- R6: If n <= 0, n is replaced by 64 (n_int 1, fraction 0) and uf_o is set.
- R7: After the R6 step, if n >> 6 exceeds max_n_i, n is replaced by max_n_i*64 and of_o is set. Both flags may be set together.
- R8: sdm_o is bits [15:8] of (fraction*128 - 4096) in two's complement. For example, fraction 0 gives 0xF0, 32 gives 0x00 and 63 gives 0x0F.
- R9: After reset, n_int_o, sdm_o, uf_o, of_o and done_o are zero. The result outputs change only in a cycle where done_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch a calculation |
| ready_o | output | 1 | Idle, able to accept start_i |
| n_eff_i | input | N_W (10) | Requested effective divider, integer |
| uv_i | input | UV_W (21) | Present supply in microvolts |
| det_offs_i | input | UV_W (21) | Detector offset in microvolts |
| det_slope_i | input | SLOPE_W (16) | Detector slope in microvolts per code, nonzero |
| ext_cal_i | input | CAL_W (7) | Applied calibration code, signed |
| det_max_i | input | CAL_W (7) | Upper limit of the detector delta, signed |
| coeff_i | input | COEFF_W (7) | Detection coefficient |
| max_n_i | input | N_W (10) | Largest legal integer divider |
| done_o | output | 1 | One-cycle result strobe |
| n_int_o | output | N_W (10) | Integer divider |
| sdm_o | output | SDM_W (8) | Sigma-delta fraction word |
| uf_o | output | 1 | Divider forced up to one |
| of_o | output | 1 | Divider forced down to max_n_i |

## Verification
The assertions check the following on every cycle:
- the handshake: ready drops after an accepted start, done is a single-cycle pulse, and ready is high with done;
- that the result outputs hold between done pulses;
- the fixed fraction word implied by each clamp;
- the two legal bands of sdm_o.

Only the bench's scenarios, compared cycle by cycle against a behavioural model, can show the arithmetic. That covers rounding at exact half quotients of either sign, clipping at the detection maximum, negative corrections, simultaneous underflow and overflow, and the exact latency.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } fdiv_state_e;

  // bits of the sigma-delta intermediate dropped below the output byte
  localparam int unsigned SDM_DROP_W = 8;
endpackage

// File: rtl/fdiv_rnd_div.sv
// Sequential signed divider, one quotient bit per cycle, round half away from zero.
module fdiv_rnd_div #(
  parameter int DVD_W = 21,
  parameter int DVS_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [DVD_W:0]     dvd_i,
  input  logic [DVS_W-1:0]   dvs_i,
  output logic               done_o,
  output logic [DVD_W+1:0]   quo_o
);
  localparam int CNT_W = $clog2(DVD_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DVD_W - 1);

  logic               busy_q, done_q, neg_q;
  logic [DVD_W-1:0]   quo_q;
  logic [DVS_W-1:0]   rem_q, dvs_q;
  logic [CNT_W-1:0]   cnt_q;

  logic [DVD_W:0]     dvd_abs;
  logic               unused_dvd_msb;
  logic [DVS_W:0]     shf;
  logic               take;
  logic [DVS_W-1:0]   rem_nx;
  logic [DVD_W-1:0]   quo_nx;
  logic               rnd_up;
  logic [DVD_W+1:0]   mag;

  assign dvd_abs        = dvd_i[DVD_W] ? (~dvd_i + 1'b1) : dvd_i;
  assign unused_dvd_msb = dvd_abs[DVD_W];

  assign shf    = {rem_q, quo_q[DVD_W-1]};
  assign take   = shf >= {1'b0, dvs_q};
  assign rem_nx = take ? (shf[DVS_W-1:0] - dvs_q) : shf[DVS_W-1:0];
  assign quo_nx = {quo_q[DVD_W-2:0], take};

  // remainder at least half the divisor rounds the magnitude up
  assign rnd_up = {rem_q, 1'b0} >= {1'b0, dvs_q};
  assign mag    = {2'b00, quo_q} + {{(DVD_W+1){1'b0}}, rnd_up};
  assign quo_o  = neg_q ? (~mag + 1'b1) : mag;
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      neg_q  <= 1'b0;
      quo_q  <= '0;
      rem_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        neg_q  <= dvd_i[DVD_W];
        quo_q  <= dvd_abs[DVD_W-1:0];
        rem_q  <= '0;
        dvs_q  <= dvs_i;
      end else if (busy_q) begin
        quo_q <= quo_nx;
        rem_q <= rem_nx;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fdiv_fold.sv
// Folds the detector correction into the fixed-point divider and clamps it.
module fdiv_fold #(
  parameter int Q_W     = 23,
  parameter int CAL_W   = 7,
  parameter int COEFF_W = 7,
  parameter int N_W     = 10,
  parameter int FRAC_W  = 6
) (
  input  logic [Q_W-1:0]     code_i,
  input  logic [CAL_W-1:0]   ext_cal_i,
  input  logic [CAL_W-1:0]   det_max_i,
  input  logic [COEFF_W-1:0] coeff_i,
  input  logic [N_W-1:0]     n_eff_i,
  input  logic [N_W-1:0]     max_n_i,
  output logic [N_W-1:0]     n_int_o,
  output logic [FRAC_W-1:0]  frac_o,
  output logic               uf_o,
  output logic               of_o
);
  localparam int ACC_W = Q_W + COEFF_W + N_W + FRAC_W + 4;
  localparam int HI_W  = ACC_W - FRAC_W;

  logic signed [ACC_W-1:0] code_x, cal_x, max_x, dlt, clip, coef_x, prod, base, n_raw, n_a;
  logic [HI_W-1:0]         lim_hi;

  assign code_x = {{(ACC_W-Q_W){code_i[Q_W-1]}}, code_i};
  assign cal_x  = {{(ACC_W-CAL_W){ext_cal_i[CAL_W-1]}}, ext_cal_i};
  assign max_x  = {{(ACC_W-CAL_W){det_max_i[CAL_W-1]}}, det_max_i};
  assign coef_x = {{(ACC_W-COEFF_W){1'b0}}, coeff_i};
  assign base   = {{(ACC_W-N_W-FRAC_W){1'b0}}, n_eff_i, {FRAC_W{1'b0}}};

  assign dlt   = code_x - cal_x;
  assign clip  = (dlt > max_x) ? max_x : dlt;
  assign prod  = clip * coef_x;
  assign n_raw = base - prod;

  assign uf_o = n_raw[ACC_W-1] | (n_raw == '0);
  assign n_a  = uf_o ? {{(ACC_W-FRAC_W-1){1'b0}}, 1'b1, {FRAC_W{1'b0}}} : n_raw;

  assign lim_hi = {{(HI_W-N_W){1'b0}}, max_n_i};
  assign of_o   = n_a[ACC_W-1:FRAC_W] > lim_hi;

  assign n_int_o = of_o ? max_n_i : n_a[FRAC_W+N_W-1:FRAC_W];
  assign frac_o  = of_o ? '0 : n_a[FRAC_W-1:0];
endmodule

// File: rtl/fdiv_sdm_enc.sv
// Re-encodes the divider fraction as an offset-binary modulator word.
module fdiv_sdm_enc
  import fdiv_pkg::*;
#(
  parameter int FRAC_W    = 6,
  parameter int SDM_RANGE = 12,
  parameter int SDM_W     = 8
) (
  input  logic [FRAC_W-1:0] frac_i,
  output logic [SDM_W-1:0]  sdm_o
);
  localparam int SH  = SDM_RANGE + 1 - FRAC_W;
  localparam int T_W = SDM_W + SDM_DROP_W;

  logic [T_W-1:0] scaled, half, t;
  logic           unused_low;

  assign scaled = T_W'({frac_i, {SH{1'b0}}});
  assign half   = T_W'(1) << SDM_RANGE;
  assign t      = scaled - half;

  assign sdm_o      = t[T_W-1:SDM_DROP_W];
  assign unused_low = ^t[SDM_DROP_W-1:0];
endmodule

// File: rtl/fdiv_calc.sv
module fdiv_calc
  import fdiv_pkg::*;
#(
  parameter int UV_W      = 21,
  parameter int SLOPE_W   = 16,
  parameter int CAL_W     = 7,
  parameter int COEFF_W   = 7,
  parameter int N_W       = 10,
  parameter int FRAC_W    = 6,
  parameter int SDM_RANGE = 12,
  parameter int SDM_W     = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  output logic               ready_o,
  input  logic [N_W-1:0]     n_eff_i,
  input  logic [UV_W-1:0]    uv_i,
  input  logic [UV_W-1:0]    det_offs_i,
  input  logic [SLOPE_W-1:0] det_slope_i,
  input  logic [CAL_W-1:0]   ext_cal_i,
  input  logic [CAL_W-1:0]   det_max_i,
  input  logic [COEFF_W-1:0] coeff_i,
  input  logic [N_W-1:0]     max_n_i,
  output logic               done_o,
  output logic [N_W-1:0]     n_int_o,
  output logic [SDM_W-1:0]   sdm_o,
  output logic               uf_o,
  output logic               of_o
);
  localparam int Q_W = UV_W + 2;

  fdiv_state_e        state_q;
  logic               accept;
  logic [UV_W:0]      diff;
  logic               div_done;
  logic [Q_W-1:0]     code;

  logic [N_W-1:0]     n_eff_q, max_n_q;
  logic [CAL_W-1:0]   ext_cal_q, det_max_q;
  logic [COEFF_W-1:0] coeff_q;

  logic [N_W-1:0]     n_int_w;
  logic [FRAC_W-1:0]  frac_w;
  logic               uf_w, of_w;
  logic [SDM_W-1:0]   sdm_w;

  logic               done_q, uf_q, of_q;
  logic [N_W-1:0]     n_int_q;
  logic [SDM_W-1:0]   sdm_q;

  assign ready_o = (state_q == ST_IDLE);
  assign accept  = start_i & ready_o;
  assign diff    = {1'b0, uv_i} - {1'b0, det_offs_i};

  fdiv_rnd_div #(
    .DVD_W (UV_W),
    .DVS_W (SLOPE_W)
  ) i_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept),
    .dvd_i   (diff),
    .dvs_i   (det_slope_i),
    .done_o  (div_done),
    .quo_o   (code)
  );

  fdiv_fold #(
    .Q_W     (Q_W),
    .CAL_W   (CAL_W),
    .COEFF_W (COEFF_W),
    .N_W     (N_W),
    .FRAC_W  (FRAC_W)
  ) i_fold (
    .code_i    (code),
    .ext_cal_i (ext_cal_q),
    .det_max_i (det_max_q),
    .coeff_i   (coeff_q),
    .n_eff_i   (n_eff_q),
    .max_n_i   (max_n_q),
    .n_int_o   (n_int_w),
    .frac_o    (frac_w),
    .uf_o      (uf_w),
    .of_o      (of_w)
  );

  fdiv_sdm_enc #(
    .FRAC_W    (FRAC_W),
    .SDM_RANGE (SDM_RANGE),
    .SDM_W     (SDM_W)
  ) i_sdm (
    .frac_i (frac_w),
    .sdm_o  (sdm_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      n_eff_q   <= '0;
      max_n_q   <= '0;
      ext_cal_q <= '0;
      det_max_q <= '0;
      coeff_q   <= '0;
      done_q    <= 1'b0;
      n_int_q   <= '0;
      sdm_q     <= '0;
      uf_q      <= 1'b0;
      of_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q   <= ST_BUSY;
          n_eff_q   <= n_eff_i;
          max_n_q   <= max_n_i;
          ext_cal_q <= ext_cal_i;
          det_max_q <= det_max_i;
          coeff_q   <= coeff_i;
        end
        ST_BUSY: if (div_done) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
          n_int_q <= n_int_w;
          sdm_q   <= sdm_w;
          uf_q    <= uf_w;
          of_q    <= of_w;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o  = done_q;
  assign n_int_o = n_int_q;
  assign sdm_o   = sdm_q;
  assign uf_o    = uf_q;
  assign of_o    = of_q;
endmodule

// File: rtl/fdiv_calc_chk.sv
module fdiv_calc_chk #(
  parameter int N_W       = 10,
  parameter int SDM_RANGE = 12,
  parameter int SDM_W     = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             ready_o,
  input logic             done_o,
  input logic [N_W-1:0]   n_int_o,
  input logic [SDM_W-1:0] sdm_o,
  input logic             uf_o,
  input logic             of_o
);
  // modulator word for a zero fraction, and the first positive word that is illegal
  localparam logic [SDM_W-1:0] SDM_ZERO = SDM_W'((1 << SDM_W) - (1 << (SDM_RANGE - 8)));
  localparam logic [SDM_W-1:0] SDM_POS_LIM = SDM_W'(1 << (SDM_RANGE - 8));

  a_r1_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && ready_o |=> !ready_o);

  a_r2_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r2_ready_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ready_o);

  a_r9_hold_between_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable({n_int_o, sdm_o, uf_o, of_o}));

  a_r6_underflow_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && uf_o && !of_o |-> (n_int_o == N_W'(1)) && (sdm_o == SDM_ZERO));

  a_r7_overflow_frac: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && of_o |-> sdm_o == SDM_ZERO);

  a_r8_sdm_band: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (sdm_o[SDM_W-1] ? (sdm_o >= SDM_ZERO) : (sdm_o < SDM_POS_LIM)));
endmodule

bind fdiv_calc fdiv_calc_chk #(
  .N_W       (N_W),
  .SDM_RANGE (SDM_RANGE),
  .SDM_W     (SDM_W)
) i_fdiv_calc_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .ready_o (ready_o),
  .done_o  (done_o),
  .n_int_o (n_int_o),
  .sdm_o   (sdm_o),
  .uf_o    (uf_o),
  .of_o    (of_o)
);

// File: tb/test_fdiv_calc.sv
module test_fdiv_calc;
  localparam int CLK_PERIOD = 10;
  localparam int UV_W = 21, SLOPE_W = 16, CAL_W = 7, COEFF_W = 7, N_W = 10, SDM_W = 8;
  localparam int LAT = UV_W + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic ready, done, uf, of_f;
  logic [N_W-1:0]     n_eff = '0, max_n = '0, n_int;
  logic [UV_W-1:0]    uv = '0, offs = '0;
  logic [SLOPE_W-1:0] slope = 16'd1;
  logic [CAL_W-1:0]   ext_cal = '0, det_max = '0;
  logic [COEFF_W-1:0] coeff = '0;
  logic [SDM_W-1:0]   sdm;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fdiv_calc i_fdiv_calc (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ready_o(ready),
    .n_eff_i(n_eff), .uv_i(uv), .det_offs_i(offs), .det_slope_i(slope),
    .ext_cal_i(ext_cal), .det_max_i(det_max), .coeff_i(coeff), .max_n_i(max_n),
    .done_o(done), .n_int_o(n_int), .sdm_o(sdm), .uf_o(uf), .of_o(of_f)
  );

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic void ref_calc(
    input longint ne, input longint u, input longint o, input longint sl,
    input longint ca, input longint dm, input longint co, input longint mn,
    output longint ni, output longint sd, output bit fu, output bit fo);
    longint d, mag, q, r, dl, n, fr, t;
    d = u - o;
    mag = (d < 0) ? -d : d;
    q = mag / sl;
    r = mag % sl;
    if (2 * r >= sl) q++;              // R3 ties away from zero
    if (d < 0) q = -q;
    dl = q - ca;
    if (dl > dm) dl = dm;              // R4 clip
    dl = dl * co;
    n = ne * 64 - dl;                  // R5
    fu = 0; fo = 0;
    if (n <= 0) begin n = 64; fu = 1; end           // R6
    if ((n >>> 6) > mn) begin n = mn * 64; fo = 1; end  // R7
    ni = n >>> 6;
    fr = n & 63;
    t = fr * 128 - 4096;               // R8
    sd = (t >>> 8) & 255;
  endfunction

  // cycle-accurate behavioural model
  bit     m_busy = 0;
  int     m_cnt = 0;
  bit     e_done = 0, e_uf = 0, e_of = 0, p_uf, p_of;
  longint e_nint = 0, e_sdm = 0, p_nint, p_sdm;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; e_done = 0; e_nint = 0; e_sdm = 0; e_uf = 0; e_of = 0;
    end else begin
      e_done = 0;
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == LAT) begin
          m_busy = 0; e_done = 1;
          e_nint = p_nint; e_sdm = p_sdm; e_uf = p_uf; e_of = p_of;
        end
      end else if (start) begin
        m_busy = 1; m_cnt = 0;
        ref_calc(n_eff, uv, offs, slope, longint'($signed(ext_cal)), longint'($signed(det_max)),
                 coeff, max_n, p_nint, p_sdm, p_uf, p_of);
      end
    end
  end

  always @(negedge clk) begin
    chk("R1", "ready", ready, !m_busy);
    chk("R2", "done", done, e_done);
    chk("R5", "n_int", n_int, e_nint);
    chk("R8", "sdm", sdm, e_sdm);
    chk("R6", "uf", uf, e_uf);
    chk("R7", "of", of_f, e_of);
  end

  task automatic drive(input int ne, input int u, input int o, input int sl,
                       input int ca, input int dm, input int co, input int mn);
    n_eff = N_W'(ne); uv = UV_W'(u); offs = UV_W'(o); slope = SLOPE_W'(sl);
    ext_cal = CAL_W'(ca); det_max = CAL_W'(dm); coeff = COEFF_W'(co); max_n = N_W'(mn);
  endtask

  task automatic wait_done();
    int k = 0;
    while (!done && k < LAT + 10) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic run_case(input string tag, input int ne, input int u, input int o, input int sl,
                          input int ca, input int dm, input int co, input int mn);
    longint ni, sd;
    bit fu, fo;
    ref_calc(ne, u, o, sl, ca, dm, co, mn, ni, sd, fu, fo);
    @(negedge clk);
    drive(ne, u, o, sl, ca, dm, co, mn);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    chk(tag, "done seen", done, 1);
    chk(tag, "n_int", n_int, ni);
    chk(tag, "sdm", sdm, sd);
    chk(tag, "uf", uf, fu);
    chk(tag, "of", of_f, fo);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_err++;
    $display("FAIL R2 watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    longint ni, sd;
    bit fu, fo;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9", "reset ready", ready, 1);
    chk("R9", "reset done", done, 0);
    chk("R9", "reset n_int", n_int, 0);
    chk("R9", "reset sdm", sdm, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 zero correction: exact code equals ext_cal
    run_case("R5", 100, 1000000, 900000, 10000, 10, 0, 50, 1023);
    chk("R8", "zero fraction word", sdm, 8'hF0);
    // R3 positive tie 1.5 -> 2
    run_case("R3", 50, 1015000, 1000000, 10000, 0, 63, 1, 1023);
    // R3 negative tie -1.5 -> -2, negative correction
    run_case("R3", 50, 900000, 915000, 10000, 0, 63, 5, 1023);
    // R3 just below half rounds down
    run_case("R3", 40, 1014999, 1000000, 10000, 0, 63, 7, 1023);
    // R4 clip at det_max
    run_case("R4", 80, 1000000, 900000, 10000, 0, 3, 20, 1023);
    // R4 negative det_max with negative ext_cal
    run_case("R4", 80, 800000, 900000, 10000, -20, -5, 9, 1023);
    // R8 half fraction: n = 64*10 + 32
    run_case("R8", 10, 1000000, 1000000, 1000, 1, 63, 32, 1023);
    chk("R8", "half fraction word", sdm, 8'h00);
    // R6 underflow
    run_case("R6", 0, 1500000, 1000000, 10000, 0, 63, 10, 1023);
    // R7 overflow
    run_case("R7", 100, 1000000, 1000000, 10000, 0, 0, 0, 20);
    // R6/R7 both with max_n zero
    run_case("R7", 0, 1500000, 1000000, 10000, 0, 63, 10, 0);
    chk("R7", "both flags uf", uf, 1);
    // R2 back-to-back: next case starts in the done cycle's follow-up
    run_case("R2", 1023, 2000000, 0, 65535, 30, 63, 127, 1023);

    // R1 start and input changes while busy are ignored
    ref_calc(77, 1200000, 1000000, 9000, 5, 63, 3, 1023, ni, sd, fu, fo);
    @(negedge clk);
    drive(77, 1200000, 1000000, 9000, 5, 63, 3, 1023);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    drive(3, 500000, 1900000, 777, -60, 0, 100, 2);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    chk("R1", "busy start ignored n_int", n_int, ni);
    chk("R1", "busy start ignored sdm", sdm, sd);
    chk("R1", "busy start ignored uf", uf, fu);
    repeat (4) @(negedge clk);
    // R9 hold after done
    chk("R9", "held n_int", n_int, ni);
    chk("R9", "held sdm", sdm, sd);

    for (int i = 0; i < 24; i++) begin
      run_case("R5", int'($urandom_range(0, 1023)), int'($urandom_range(600000, 1300000)),
               int'($urandom_range(400000, 1100000)), int'($urandom_range(1000, 20000)),
               int'($urandom_range(0, 127)) - 64, int'($urandom_range(0, 127)) - 64,
               int'($urandom_range(0, 127)), int'($urandom_range(1, 1023)));
    end

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule